// File: doc/BRIEF.md
# Subcode Sync and Serial Extractor

This block sits behind the channel demodulator of an optical-disc read path and deals with the one subcode byte that arrives in each frame. A frame tick marks each frame. On that tick the block looks at the 14-bit channel word and checks it for the two subcode sync patterns. It also registers the decoded subcode byte. A block-start strobe follows one frame after a sync is seen, and it carries flags that tell which of the two patterns it was.

The Q channel bit of the registered byte drives a dedicated output. The full byte of eight channel bits (P down to W) is loaded into a shift register. An external shift clock then reads that register out serially. This clock is sampled into the block's own clock domain.

In parallel, the block checks the Q bits of every 98-frame block: two sync frames, then 96 data frames. It runs a 16-bit CRC over them. The pass/fail verdict appears on a flag that changes together with the next block-start strobe.

Top module: `subcode_extractor`

## Requirements
- R1: On a frame tick with `sym_valid` high, the word 14'b00100000000001 is recognised as the first sync pattern and 14'b00000000010010 as the second. Any other word, or any word seen while `sym_valid` is low, is not recognised.
- R2: `blk_strobe` goes high at the frame tick that follows the tick on which a sync was recognised. It then stays high for exactly one frame, and it changes only at frame ticks.
- R3: While `blk_strobe` is high, `flag_s0` and `flag_s1` show which pattern caused it. Both flags are low whenever `blk_strobe` is low.
- R4: At each frame tick the subcode byte is registered, and `q_bit` follows bit 6 of that byte. Bit 7 is P and bit 0 is W. `q_bit` changes only at frame ticks.
- R5: At each frame tick the byte is loaded into the serial register, and `pw_serial` shows bit 7 (P) at once. Each rising edge of `shift_clk_in` moves the next lower bit onto `pw_serial`, three clock cycles after the edge. After eight edges the output is 0.
- R6: When a shift edge and a frame tick take effect in the same cycle, the load wins and no shift is applied to the new byte.
- R7: The CRC uses the polynomial x^16+x^12+x^5+1, starts from 0 and takes bits MSB-first. It runs over the 96 Q bits that follow a sync pair. The last 16 of those bits carry the inverted checksum. `crc_ok` takes the verdict of the previous block at the tick where `blk_strobe` rises, and it holds that value until the next rise.
- R8: After reset, `blk_strobe`, `flag_s0`, `flag_s1`, `q_bit` and `pw_serial` are 0 and `crc_ok` is 1.
- R9: A block that ends with any number of data frames other than 96 gives a failing verdict (`crc_ok` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| sym_valid | input | 1 | Channel word on `sym_word` is valid |
| sym_word | input | 14 | Channel word checked for sync patterns |
| sub_byte | input | 8 | Demodulated subcode byte, P in bit 7 |
| shift_clk_in | input | 1 | External shift clock for serial readout |
| blk_strobe | output | 1 | Block-start strobe, one frame long |
| flag_s0 | output | 1 | First sync pattern seen, valid with strobe |
| flag_s1 | output | 1 | Second sync pattern seen, valid with strobe |
| q_bit | output | 1 | Q channel bit of the registered byte |
| pw_serial | output | 1 | Serial P–W data, MSB first |
| crc_ok | output | 1 | Q CRC verdict of the previous block |

## Verification
The verdict flag is the hardest output to steer from the ports. It changes only after a whole 96-frame block has been sent and a second sync pair has followed it. A checksum mistake inside the block stays invisible until that later strobe. For this reason the bench computes a proper inverted checksum for an 80-bit message. It then sends a corrupted block, a clean block and a block one frame short, one after another, so that the flag has to fall, rise and fall again. The race between a load and a shift is reached by lining up the synchronised shift edge with a frame tick, counting the delay of the synchroniser stages.

// File: rtl/subcode_pkg.sv
package subcode_pkg;

  typedef struct packed {
    logic s0;
    logic s1;
  } sync_hit_t;

  // One serial step of an MSB-first CRC register.
  function automatic logic [15:0] crc16_step(input logic [15:0] rem,
                                             input logic        din,
                                             input logic [15:0] poly);
    logic fb;
    fb = rem[15] ^ din;
    return {rem[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/subc_sync_detect.sv
module subc_sync_detect
  import subcode_pkg::*;
#(
  parameter int                WORD_W = 14,
  parameter logic [WORD_W-1:0] S0_PAT = 14'b00100000000001,
  parameter logic [WORD_W-1:0] S1_PAT = 14'b00000000010010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              sym_valid,
  input  logic [WORD_W-1:0] sym_word,
  output sync_hit_t         hit,
  output logic              strobe_set,
  output logic              blk_strobe,
  output logic              flag_s0,
  output logic              flag_s1
);

  sync_hit_t pend_q, pend_d;
  sync_hit_t flg_q, flg_d;
  logic      strb_q, strb_d;

  always_comb begin
    hit.s0 = sym_valid && (sym_word == S0_PAT);
    hit.s1 = sym_valid && (sym_word == S1_PAT);
  end

  assign strobe_set = frame_tick && (pend_q.s0 || pend_q.s1);

  always_comb begin
    pend_d = pend_q;
    flg_d  = flg_q;
    strb_d = strb_q;
    if (frame_tick) begin
      pend_d = hit;
      strb_d = pend_q.s0 || pend_q.s1;
      flg_d  = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      flg_q  <= '0;
      strb_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flg_q  <= flg_d;
      strb_q <= strb_d;
    end
  end

  assign blk_strobe = strb_q;
  assign flag_s0    = strb_q & flg_q.s0;
  assign flag_s1    = strb_q & flg_q.s1;

endmodule

// File: rtl/subc_pw_shifter.sv
module subc_pw_shifter #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [BYTE_W-1:0] sub_byte,
  input  logic              shift_clk_in,
  output logic              q_bit,
  output logic              pw_serial
);

  localparam int CHAIN_W = SYNC_STAGES + 1;
  localparam int Q_POS   = BYTE_W - 2;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic [BYTE_W-1:0]  byte_q, byte_d;
  logic [BYTE_W-1:0]  sreg_q, sreg_d;
  logic               shift_edge;

  assign chain_d    = {chain_q[CHAIN_W-2:0], shift_clk_in};
  assign shift_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  always_comb begin
    byte_d = byte_q;
    sreg_d = sreg_q;
    if (frame_tick) begin
      byte_d = sub_byte;
      sreg_d = sub_byte;
    end else if (shift_edge) begin
      sreg_d = {sreg_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      byte_q  <= '0;
      sreg_q  <= '0;
    end else begin
      chain_q <= chain_d;
      byte_q  <= byte_d;
      sreg_q  <= sreg_d;
    end
  end

  assign q_bit     = byte_q[Q_POS];
  assign pw_serial = sreg_q[BYTE_W-1];

endmodule

// File: rtl/subc_q_crc.sv
module subc_q_crc
  import subcode_pkg::*;
#(
  parameter int          Q_BITS   = 96,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic sync_any,
  input  logic q_in,
  input  logic strobe_set,
  output logic crc_ok
);

  localparam int             CNT_W    = $clog2(Q_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(Q_BITS);
  localparam logic [CNT_W-1:0] CNT_TAIL = CNT_W'(Q_BITS - CRC_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [15:0]      rem_q, rem_d;
  logic             verdict_q, verdict_d;
  logic             ok_q, ok_d;
  logic             bit_in;

  // Checksum bits are stored inverted; undo that before they enter the CRC.
  assign bit_in = q_in ^ (cnt_q >= CNT_TAIL);

  always_comb begin
    cnt_d     = cnt_q;
    rem_d     = rem_q;
    verdict_d = verdict_q;
    ok_d      = ok_q;
    if (frame_tick) begin
      if (sync_any) begin
        if (cnt_q != '0) begin
          verdict_d = (cnt_q == CNT_FULL) && (rem_q == 16'h0000);
        end
        cnt_d = '0;
        rem_d = '0;
      end else begin
        if (cnt_q < CNT_FULL) begin
          rem_d = crc16_step(rem_q, bit_in, CRC_POLY);
        end
        if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (strobe_set) begin
        ok_d = verdict_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rem_q     <= '0;
      verdict_q <= 1'b1;
      ok_q      <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      rem_q     <= rem_d;
      verdict_q <= verdict_d;
      ok_q      <= ok_d;
    end
  end

  assign crc_ok = ok_q;

endmodule

// File: rtl/subcode_extractor.sv
module subcode_extractor
  import subcode_pkg::*;
#(
  parameter int                WORD_W      = 14,
  parameter int                BYTE_W      = 8,
  parameter int                Q_BITS      = 96,
  parameter int                CRC_W       = 16,
  parameter logic [15:0]       CRC_POLY    = 16'h1021,
  parameter logic [WORD_W-1:0] S0_PAT      = 14'b00100000000001,
  parameter logic [WORD_W-1:0] S1_PAT      = 14'b00000000010010,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              sym_valid,
  input  logic [WORD_W-1:0] sym_word,
  input  logic [BYTE_W-1:0] sub_byte,
  input  logic              shift_clk_in,
  output logic              blk_strobe,
  output logic              flag_s0,
  output logic              flag_s1,
  output logic              q_bit,
  output logic              pw_serial,
  output logic              crc_ok
);

  localparam int Q_POS = BYTE_W - 2;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  sync_hit_t  hit;
  logic       strobe_set;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  subc_sync_detect #(
    .WORD_W(WORD_W), .S0_PAT(S0_PAT), .S1_PAT(S1_PAT)
  ) u_sync (
    .clk(clk), .rst_n(rst_core_n), .frame_tick(frame_tick),
    .sym_valid(sym_valid), .sym_word(sym_word), .hit(hit),
    .strobe_set(strobe_set), .blk_strobe(blk_strobe),
    .flag_s0(flag_s0), .flag_s1(flag_s1)
  );

  subc_pw_shifter #(
    .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_pw (
    .clk(clk), .rst_n(rst_core_n), .frame_tick(frame_tick),
    .sub_byte(sub_byte), .shift_clk_in(shift_clk_in),
    .q_bit(q_bit), .pw_serial(pw_serial)
  );

  subc_q_crc #(
    .Q_BITS(Q_BITS), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) u_crc (
    .clk(clk), .rst_n(rst_core_n), .frame_tick(frame_tick),
    .sync_any(hit.s0 | hit.s1), .q_in(sub_byte[Q_POS]),
    .strobe_set(strobe_set), .crc_ok(crc_ok)
  );

endmodule

// File: rtl/subc_extract_checks.sv
module subc_extract_checks (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic blk_strobe,
  input logic flag_s0,
  input logic flag_s1,
  input logic q_bit,
  input logic crc_ok
);

  a_r3_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_strobe |-> (!flag_s0 && !flag_s1));

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_s0, flag_s1}));

  a_r2_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(blk_strobe));

  a_r4_q_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(q_bit));

  a_r7_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blk_strobe) && blk_strobe |-> $past(frame_tick));

  a_r7_crc_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_strobe && !$past(blk_strobe)) |-> $stable(crc_ok));

endmodule

bind subcode_extractor subc_extract_checks i_checks (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
  .blk_strobe(blk_strobe), .flag_s0(flag_s0), .flag_s1(flag_s1),
  .q_bit(q_bit), .crc_ok(crc_ok)
);

// File: tb/test_subcode_extractor.sv
`timescale 1ns/1ps
module test_subcode_extractor;

  localparam logic [13:0] S0 = 14'b00100000000001;
  localparam logic [13:0] S1 = 14'b00000000010010;

  typedef struct packed {
    logic        v;
    logic [13:0] w;
    logic [7:0]  b;
    logic        st;
    logic        e0;
    logic        e1;
    logic        eq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, S0,            8'h40, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, S1,            8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 14'h0123,      8'hFF, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, S0,            8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, S0 ^ 14'h0001, 8'h40, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, S1,            8'hBF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 14'h0000,      8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 14'h0000,      8'h00, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  localparam logic [79:0] MSG = 80'hA5C3_1F00_9E27_4B6D_8813;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        sym_valid = 1'b0;
  logic [13:0] sym_word = '0;
  logic [7:0]  sub_byte = '0;
  logic        shift_clk_in = 1'b0;
  logic        blk_strobe, flag_s0, flag_s1, q_bit, pw_serial, crc_ok;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  subcode_extractor i_subcode_extractor (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .sym_valid(sym_valid), .sym_word(sym_word), .sub_byte(sub_byte),
    .shift_clk_in(shift_clk_in), .blk_strobe(blk_strobe),
    .flag_s0(flag_s0), .flag_s1(flag_s1), .q_bit(q_bit),
    .pw_serial(pw_serial), .crc_ok(crc_ok)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One frame: inputs at a falling edge, sampled at the next falling edge.
  task automatic tick(input logic v, input logic [13:0] w, input logic [7:0] b);
    sym_valid  = v;
    sym_word   = w;
    sub_byte   = b;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    sym_valid  = 1'b0;
  endtask

  task automatic pulse_shift();
    shift_clk_in = 1'b1;
    repeat (4) @(negedge clk);
    shift_clk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] ref_crc(input logic [79:0] m);
    logic [15:0] r;
    r = '0;
    for (int k = 79; k >= 0; k--) begin
      if (r[15] ^ m[k]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic send_pair();
    tick(1'b1, S0, 8'h00);
    tick(1'b1, S1, 8'h00);
  endtask

  // kind 0: clean block, 1: one flipped bit, 2: 95 frames only.
  task automatic send_data(input int kind);
    logic [95:0] bits;
    int n;
    bits = {MSG, ~ref_crc(MSG)};
    if (kind == 1) bits[40] = ~bits[40];
    n = (kind == 2) ? 95 : 96;
    for (int k = 0; k < n; k++) tick(1'b1, 14'h0000, {1'b0, bits[95-k], 6'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R8 reset state
    check("R8 strobe", blk_strobe, 0);
    check("R8 flags", {flag_s0, flag_s1}, 0);
    check("R8 q_bit", q_bit, 0);
    check("R8 pw_serial", pw_serial, 0);
    check("R8 crc_ok", crc_ok, 1);

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      tick(VECS[i].v, VECS[i].w, VECS[i].b);
      check("R1 R2 strobe", blk_strobe, VECS[i].st);
      check("R3 flag_s0", flag_s0, VECS[i].e0);
      check("R3 flag_s1", flag_s1, VECS[i].e1);
      check("R4 q_bit", q_bit, VECS[i].eq);
      repeat (2) @(negedge clk);
      check("R2 strobe held between ticks", blk_strobe, VECS[i].st);
    end

    // R5 serial readout, MSB first
    do_reset();
    tick(1'b1, 14'h0000, 8'hB4);
    check("R5 first bit", pw_serial, 1);
    check("R4 q_bit of B4", q_bit, 0);
    for (int k = 1; k <= 9; k++) begin
      logic [7:0] pat;
      pat = 8'hB4;
      pulse_shift();
      check("R5 shifted bit", pw_serial, (k < 8) ? pat[7-k] : 1'b0);
    end

    // R6 load beats a coincident shift
    tick(1'b1, 14'h0000, 8'h3C);
    check("R5 reload", pw_serial, 0);
    shift_clk_in = 1'b1;
    repeat (2) @(negedge clk);
    sub_byte   = 8'h81;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    check("R6 load wins", pw_serial, 1);
    repeat (3) @(negedge clk);
    shift_clk_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 no extra shift", pw_serial, 1);
    pulse_shift();
    check("R6 next bit", pw_serial, 0);

    // R7 R9 Q CRC over whole blocks
    do_reset();
    send_pair();
    send_data(1);
    check("R7 hold before strobe", crc_ok, 1);
    send_pair();
    check("R7 strobe with verdict", blk_strobe, 1);
    check("R7 corrupted block", crc_ok, 0);
    send_data(0);
    check("R7 hold within block", crc_ok, 0);
    send_pair();
    check("R7 clean block", crc_ok, 1);
    send_data(2);
    send_pair();
    check("R9 short block", crc_ok, 0);
    send_data(0);
    send_pair();
    check("R7 recovery", crc_ok, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule